// File: doc/BRIEF.md
# NAND Flash Bus Interface Controller

This block is a register-mapped peripheral that drives a raw 8-bit NAND flash device. Software runs each flash bus cycle by hand. It sets level bits in a mode register for the command latch, the address latch, chip enable, chip select and write enable. It then reads or writes the data register. Each data register access becomes one timed strobe on the flash bus. The strobe width and the data hold time come from a timing register and are counted in bus clocks.

The register bus is a simple strobe interface: `reg_we_i` or `reg_re_i` is sampled with `reg_addr_i` on a rising clock edge while `reg_ready_o` is high. Reads of plain registers return their value on `reg_rdata_o` from the edge after that sample. A read of the data register returns the flash byte once `reg_ready_o` rises again. The ready/busy pin of the flash passes through a two-stage synchronizer. It feeds the busy status bit, and its rising edge sets a maskable interrupt flag. A self-clearing reset bit returns the controller to idle in one clock.

Top module: `nand_bus_ctrl`

## Requirements
- R1: Registers sit at byte offsets data 0x00, mode 0x04, status 0x08, interrupt flag 0x0C, interrupt mask 0x10, timing 0x14 and reset 0x18. The mode register reads back all 8 written bits, the timing register all 8 bits, and the mask register bit 0. Each value is readable on `reg_rdata_o` one clock after the accepted read.
- R2: A write to the data register while any of mode bits 0, 1 or 7 is set starts a write cycle. `fl_we_no` is low for SPW+1 clocks and then high for HOLD+2 clocks. `fl_dq_o` carries the written byte and `fl_dq_oe_o` is high through both phases. SPW is timing bits 3:0 and HOLD is timing bits 7:4.
- R3: A write to the data register with mode bits 0, 1 and 7 all clear produces no strobe, and `reg_ready_o` stays high.
- R4: A read of the data register holds `fl_re_no` low for SPW+1 clocks and then high for HOLD+2 clocks. The byte on `fl_dq_i` in the last strobe clock appears on `reg_rdata_o` when `reg_ready_o` returns high.
- R5: With mode bit 4 set, `fl_ce_no[cs]` is low, where cs is mode bits 3:2, and every other chip-select line is high. With bit 4 clear, all lines are high.
- R6: `fl_cle_o` follows mode bit 0 and `fl_ale_o` follows mode bit 1.
- R7: Status bit 7 reads 1 while the synchronized ready/busy pin is low or a cycle is running, and 0 otherwise.
- R8: A rising edge of the synchronized ready/busy pin sets interrupt flag bit 0. Writing 1 to that bit clears it. `irq_o` is the flag ANDed with mask bit 0.
- R9: A write of 1 to reset bit 0 is taken even while a cycle runs. On the next clock it clears the mode, timing, flag and mask registers, ends any cycle, and clears itself. `reg_ready_o` is high again two clocks after the reset write is sampled.
- R10: Every register access other than a reset write is ignored while `reg_ready_o` is low, and `reg_ready_o` is low for the whole of every flash cycle.
- R11: After the asynchronous reset, all chip-select lines, `fl_we_no` and `fl_re_no` are high, `reg_ready_o` is high, and the mode and timing registers read 0.
- R12: `fl_we_no` and `fl_re_no` are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 5 | Register byte offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_rdata_o | output | 8 | Register read data |
| reg_ready_o | output | 1 | High when an access can be accepted |
| irq_o | output | 1 | Masked ready-edge interrupt |
| fl_cle_o | output | 1 | Command latch enable |
| fl_ale_o | output | 1 | Address latch enable |
| fl_ce_no | output | 4 | Chip-select lines, active low |
| fl_we_no | output | 1 | Write strobe, active low |
| fl_re_no | output | 1 | Read strobe, active low |
| fl_dq_o | output | 8 | Flash data out |
| fl_dq_oe_o | output | 1 | Flash data output enable |
| fl_dq_i | input | 8 | Flash data in |
| fl_rb_i | input | 1 | Flash ready/busy, low while busy |

## Verification
A flash cycle begins on the edge that accepts the access. The bench samples on every falling edge after that point and counts strobe clocks and hold clocks until ready returns. The counts must equal SPW+1 and HOLD+2 exactly, and the read byte is compared at the first falling edge with ready high. Register reads are checked one falling edge after the accepting edge. Changes on the ready/busy pin are checked three clocks later, which covers two synchronizer stages and the flag register. After a reset write, ready and idle strobes are checked two edges after the accepting edge.

// File: rtl/nbc_pkg.sv
package nbc_pkg;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_DATA = 5'h00;
  localparam logic [ADDR_W-1:0] A_MODE = 5'h04;
  localparam logic [ADDR_W-1:0] A_STAT = 5'h08;
  localparam logic [ADDR_W-1:0] A_FLAG = 5'h0C;
  localparam logic [ADDR_W-1:0] A_MASK = 5'h10;
  localparam logic [ADDR_W-1:0] A_TIME = 5'h14;
  localparam logic [ADDR_W-1:0] A_RST  = 5'h18;

  localparam int MB_CLE = 0;
  localparam int MB_ALE = 1;
  localparam int MB_CS  = 2;
  localparam int MB_CE  = 4;
  localparam int MB_WEN = 7;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_STROBE,
    PH_HOLD
  } phase_e;
endpackage

// File: rtl/nbc_sync.sv
module nbc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign sync_o = sh_q[STAGES-1];
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/nbc_cycle.sv
module nbc_cycle
  import nbc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              start_wr_i,
  input  logic              start_rd_i,
  input  logic [DATA_W-1:0] wbyte_i,
  input  logic [CNT_W-1:0]  spw_i,
  input  logic [CNT_W-1:0]  hold_i,
  output logic              active_o,
  output logic              we_no,
  output logic              re_no,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic              cap_o
);
  localparam int HCW = CNT_W + 1;

  phase_e            ph_q;
  logic [HCW-1:0]    cnt_q;
  logic              is_rd_q;
  logic [DATA_W-1:0] dq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      is_rd_q <= 1'b0;
      dq_q    <= '0;
    end else if (clr_i) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          if (start_wr_i || start_rd_i) begin
            ph_q    <= PH_STROBE;
            cnt_q   <= {1'b0, spw_i};
            is_rd_q <= start_rd_i;
            if (start_wr_i) dq_q <= wbyte_i;
          end
        end
        PH_STROBE: begin
          if (cnt_q == '0) begin
            ph_q  <= PH_HOLD;
            // hold phase runs HOLD+2 clocks
            cnt_q <= {1'b0, hold_i} + HCW'(1);
          end else begin
            cnt_q <= cnt_q - HCW'(1);
          end
        end
        PH_HOLD: begin
          if (cnt_q == '0) ph_q <= PH_IDLE;
          else             cnt_q <= cnt_q - HCW'(1);
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign active_o = (ph_q != PH_IDLE);
  assign we_no    = !((ph_q == PH_STROBE) && !is_rd_q);
  assign re_no    = !((ph_q == PH_STROBE) && is_rd_q);
  assign dq_o     = dq_q;
  assign dq_oe_o  = active_o && !is_rd_q;
  assign cap_o    = (ph_q == PH_STROBE) && is_rd_q && (cnt_q == '0);
endmodule

// File: rtl/nbc_regs.sv
module nbc_regs
  import nbc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic              ready_i,
  input  logic              busy_i,
  input  logic              rb_rise_i,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] cap_data_i,
  output logic [DATA_W-1:0] mode_o,
  output logic [CNT_W-1:0]  spw_o,
  output logic [CNT_W-1:0]  hold_o,
  output logic              srst_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              start_wr_o,
  output logic              start_rd_o
);
  logic [DATA_W-1:0] mode_q, time_q, rdata_q, rmux;
  logic              flag_q, mask_q, srst_q;
  logic              acc_w, acc_r;

  assign acc_w = we_i && ready_i;
  assign acc_r = re_i && ready_i;

  always_comb begin
    rmux = '0;
    unique case (addr_i)
      A_MODE:  rmux = mode_q;
      A_STAT:  rmux[DATA_W-1] = busy_i;
      A_FLAG:  rmux[0] = flag_q;
      A_MASK:  rmux[0] = mask_q;
      A_TIME:  rmux = time_q;
      A_RST:   rmux[0] = srst_q;
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      time_q <= '0;
      flag_q <= 1'b0;
      mask_q <= 1'b0;
      srst_q <= 1'b0;
    end else if (srst_q) begin
      mode_q <= '0;
      time_q <= '0;
      flag_q <= 1'b0;
      mask_q <= 1'b0;
      srst_q <= 1'b0;
    end else begin
      if (rb_rise_i) flag_q <= 1'b1;
      if (acc_w) begin
        unique case (addr_i)
          A_MODE:  mode_q <= wdata_i;
          A_FLAG:  if (wdata_i[0]) flag_q <= 1'b0;
          A_MASK:  mask_q <= wdata_i[0];
          A_TIME:  time_q <= wdata_i;
          default: ;
        endcase
      end
      // reset request bypasses the ready gate
      if (we_i && addr_i == A_RST && wdata_i[0]) srst_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        rdata_q <= '0;
    else if (cap_i)                     rdata_q <= cap_data_i;
    else if (acc_r && addr_i != A_DATA) rdata_q <= rmux;
  end

  assign start_wr_o = acc_w && addr_i == A_DATA &&
                      (mode_q[MB_CLE] || mode_q[MB_ALE] || mode_q[MB_WEN]);
  assign start_rd_o = acc_r && addr_i == A_DATA;

  assign mode_o  = mode_q;
  assign spw_o   = time_q[CNT_W-1:0];
  assign hold_o  = time_q[2*CNT_W-1:CNT_W];
  assign srst_o  = srst_q;
  assign irq_o   = flag_q && mask_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/nand_bus_ctrl.sv
module nand_bus_ctrl
  import nbc_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 4,
  parameter int NUM_CS  = 4,
  parameter int SYNC_ST = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              reg_ready_o,
  output logic              irq_o,
  output logic              fl_cle_o,
  output logic              fl_ale_o,
  output logic [NUM_CS-1:0] fl_ce_no,
  output logic              fl_we_no,
  output logic              fl_re_no,
  output logic [DATA_W-1:0] fl_dq_o,
  output logic              fl_dq_oe_o,
  input  logic [DATA_W-1:0] fl_dq_i,
  input  logic              fl_rb_i
);
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  logic [DATA_W-1:0] mode;
  logic [CNT_W-1:0]  spw, hold;
  logic              srst, active, cap, rb_s, rb_rise;
  logic              start_wr, start_rd, busy;
  logic [CS_W-1:0]   cs_sel;

  assign reg_ready_o = !active && !srst;
  assign busy        = active || !rb_s;

  nbc_sync #(.STAGES(SYNC_ST)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (fl_rb_i),
    .sync_o  (rb_s),
    .rise_o  (rb_rise)
  );

  nbc_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .we_i       (reg_we_i),
    .re_i       (reg_re_i),
    .ready_i    (reg_ready_o),
    .busy_i     (busy),
    .rb_rise_i  (rb_rise),
    .cap_i      (cap),
    .cap_data_i (fl_dq_i),
    .mode_o     (mode),
    .spw_o      (spw),
    .hold_o     (hold),
    .srst_o     (srst),
    .irq_o      (irq_o),
    .rdata_o    (reg_rdata_o),
    .start_wr_o (start_wr),
    .start_rd_o (start_rd)
  );

  nbc_cycle #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cycle (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (srst),
    .start_wr_i (start_wr),
    .start_rd_i (start_rd),
    .wbyte_i    (reg_wdata_i),
    .spw_i      (spw),
    .hold_i     (hold),
    .active_o   (active),
    .we_no      (fl_we_no),
    .re_no      (fl_re_no),
    .dq_o       (fl_dq_o),
    .dq_oe_o    (fl_dq_oe_o),
    .cap_o      (cap)
  );

  assign fl_cle_o = mode[MB_CLE];
  assign fl_ale_o = mode[MB_ALE];
  assign cs_sel   = mode[MB_CS +: CS_W];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_ce
    assign fl_ce_no[g] = !(mode[MB_CE] && cs_sel == CS_W'(g));
  end
endmodule

// File: rtl/nbc_checker.sv
module nbc_checker #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4,
  parameter int NUM_CS = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_n,
  input logic              re_n,
  input logic              dq_oe,
  input logic              ready,
  input logic [NUM_CS-1:0] ce_n,
  input logic              srst,
  input logic              active,
  input logic [DATA_W-1:0] mode
);
  localparam int MAX_STB = 1 << CNT_W;
  localparam int RUN_W   = CNT_W + 2;

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            run_q <= '0;
    else if (!we_n || !re_n) run_q <= run_q + RUN_W'(1);
    else                    run_q <= '0;
  end

  p_strobe_excl_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_n && !re_n));

  p_ready_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_n || !re_n || dq_oe) |-> !ready);

  p_dq_driven_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n |-> dq_oe);

  p_ce_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~ce_n) <= 1);

  p_srst_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> (mode == '0 && !active && !srst));

  p_strobe_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RUN_W'(MAX_STB));
endmodule

bind nand_bus_ctrl nbc_checker #(
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W),
  .NUM_CS (NUM_CS)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .we_n   (fl_we_no),
  .re_n   (fl_re_no),
  .dq_oe  (fl_dq_oe_o),
  .ready  (reg_ready_o),
  .ce_n   (fl_ce_no),
  .srst   (srst),
  .active (active),
  .mode   (mode)
);

// File: tb/nand_bus_ctrl_bench.sv
`timescale 1ns/1ps
module nand_bus_ctrl_bench;
  localparam logic [4:0] A_DATA = 5'h00, A_MODE = 5'h04, A_STAT = 5'h08,
                         A_FLAG = 5'h0C, A_MASK = 5'h10, A_TIME = 5'h14,
                         A_RST  = 5'h18;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0, re = 1'b0;
  logic [7:0] rdata;
  logic       ready, irq, cle, ale, we_n, re_n, dq_oe;
  logic [3:0] ce_n;
  logic [7:0] dq_o;
  logic [7:0] dq_i = 8'h00;
  logic       rb = 1'b1;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  nand_bus_ctrl u_nand_bus_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_we_i(we), .reg_re_i(re), .reg_rdata_o(rdata), .reg_ready_o(ready),
    .irq_o(irq), .fl_cle_o(cle), .fl_ale_o(ale), .fl_ce_no(ce_n),
    .fl_we_no(we_n), .fl_re_no(re_n), .fl_dq_o(dq_o), .fl_dq_oe_o(dq_oe),
    .fl_dq_i(dq_i), .fl_rb_i(rb)
  );

  function automatic logic [3:0] exp_ce(input logic [7:0] m);
    logic [3:0] r = 4'hF;
    if (m[4]) r[m[3:2]] = 1'b0;
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_ready();
    int g = 0;
    while (!ready && g < 200) begin @(negedge clk); g++; end
  endtask

  task automatic reg_wr(input logic [4:0] a, input logic [7:0] d);
    wait_ready();
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic reg_rd(input logic [4:0] a, output logic [7:0] d);
    wait_ready();
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    d = rdata;
  endtask

  // run one data cycle and measure strobe and hold clocks
  task automatic flash_cycle(input bit is_rd, input logic [7:0] b,
                             input int spw, input int hold, input string tag);
    int lo = 0, hd = 0, g = 0, dbad = 0;
    wait_ready();
    addr = A_DATA; wdata = b;
    if (is_rd) re = 1'b1; else we = 1'b1;
    @(negedge clk);
    we = 1'b0; re = 1'b0;
    while (!ready && g < 100) begin
      if (is_rd ? !re_n : !we_n) begin
        lo++;
        if (!is_rd && dq_o !== b) dbad++;
      end else if (is_rd || dq_oe) begin
        hd++;
      end
      @(negedge clk);
      g++;
    end
    chk(lo == spw + 1, {tag, " strobe clocks"}, lo, spw + 1);
    chk(hd == hold + 2, {tag, " hold clocks"}, hd, hold + 2);
    if (is_rd) chk(rdata === b, {tag, " read byte"}, rdata, b);
    else       chk(dbad == 0, {tag, " write byte on bus"}, dbad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v, m;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk(ce_n === 4'hF, "R11 ce lines", ce_n, 4'hF);
    chk(we_n === 1'b1 && re_n === 1'b1, "R11 strobes idle", {we_n, re_n}, 2'b11);
    chk(ready === 1'b1, "R11 ready", ready, 1);
    reg_rd(A_MODE, v); chk(v === 8'h00, "R11 mode zero", v, 0);
    reg_rd(A_TIME, v); chk(v === 8'h00, "R11 timing zero", v, 0);

    // R2 boundary: timing zero -> 1 strobe, 2 hold
    reg_wr(A_MODE, 8'h80);
    flash_cycle(1'b0, 8'hA5, 0, 0, "R2 zero timing");

    // R1 register readback
    reg_wr(A_MODE, 8'h6D); reg_rd(A_MODE, v); chk(v === 8'h6D, "R1 mode readback", v, 8'h6D);
    reg_wr(A_TIME, 8'h3C); reg_rd(A_TIME, v); chk(v === 8'h3C, "R1 timing readback", v, 8'h3C);
    reg_wr(A_MASK, 8'h01); reg_rd(A_MASK, v); chk(v === 8'h01, "R1 mask readback", v, 1);

    // R3 ignored data write
    reg_wr(A_MODE, 8'h10);
    reg_wr(A_DATA, 8'h33);
    chk(ready === 1'b1 && we_n === 1'b1 && dq_oe === 1'b0, "R3 no cycle",
        {ready, we_n, dq_oe}, 3'b110);

    // R7 / R8 ready/busy
    @(negedge clk); rb = 1'b0;
    repeat (3) @(negedge clk);
    reg_rd(A_STAT, v); chk(v[7] === 1'b1, "R7 busy while rb low", v, 8'h80);
    rb = 1'b1;
    repeat (3) @(negedge clk);
    reg_rd(A_STAT, v); chk(v[7] === 1'b0, "R7 idle after rb high", v, 0);
    reg_rd(A_FLAG, v); chk(v[0] === 1'b1, "R8 flag set on rise", v, 1);
    chk(irq === 1'b1, "R8 irq when masked in", irq, 1);
    reg_wr(A_FLAG, 8'h01);
    reg_rd(A_FLAG, v); chk(v[0] === 1'b0, "R8 flag cleared", v, 0);
    chk(irq === 1'b0, "R8 irq dropped", irq, 0);

    // R10 access during cycle ignored
    reg_wr(A_TIME, 8'hFF);
    reg_wr(A_MODE, 8'h91);
    wait_ready();
    addr = A_DATA; wdata = 8'h5A; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    @(negedge clk);
    chk(ready === 1'b0, "R10 ready low in cycle", ready, 0);
    addr = A_MODE; wdata = 8'h02; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    reg_rd(A_MODE, v); chk(v === 8'h91, "R10 mode write ignored", v, 8'h91);

    // R9 soft reset mid-cycle
    reg_wr(A_MASK, 8'h01);
    addr = A_DATA; wdata = 8'hC3; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    repeat (2) @(negedge clk);
    addr = A_RST; wdata = 8'h01; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    chk(ready === 1'b0, "R9 reset pending", ready, 0);
    @(negedge clk);
    chk(ready === 1'b1 && we_n === 1'b1 && dq_oe === 1'b0, "R9 cycle ended",
        {ready, we_n, dq_oe}, 3'b110);
    reg_rd(A_MODE, v); chk(v === 8'h00, "R9 mode cleared", v, 0);
    reg_rd(A_TIME, v); chk(v === 8'h00, "R9 timing cleared", v, 0);
    reg_rd(A_MASK, v); chk(v === 8'h00, "R9 mask cleared", v, 0);
    reg_rd(A_RST, v);  chk(v === 8'h00, "R9 bit self-cleared", v, 0);

    // random cycles: R2 R4 R5 R6
    for (int i = 0; i < 40; i++) begin
      int sp = $urandom_range(1, 15);
      int hl = $urandom_range(1, 15);
      int kind = $urandom_range(0, 3);
      logic [7:0] b = 8'($urandom);
      m = {1'b0, 2'($urandom), 1'($urandom), 2'($urandom), 2'b00};
      case (kind)
        0: m[0] = 1'b1;
        1: m[1] = 1'b1;
        2: m[7] = 1'b1;
        default: ;
      endcase
      reg_wr(A_TIME, 8'(hl << 4 | sp));
      reg_wr(A_MODE, m);
      chk(ce_n === exp_ce(m), "R5 chip select", ce_n, exp_ce(m));
      chk(cle === m[0] && ale === m[1], "R6 latch pins", {cle, ale}, {m[0], m[1]});
      if (kind == 3) begin
        dq_i = b;
        flash_cycle(1'b1, b, sp, hl, "R4 read");
      end else begin
        flash_cycle(1'b0, b, sp, hl, "R2 write");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule